// File: doc/BRIEF.md
# Keyed Byte Stream Scrambler

This block scrambles a continuous stream of bytes under a fixed 24-bit key. It takes at most one byte per clock and returns one scrambled byte per clock. The key splits into three bytes: a high byte K2, a middle byte K1 and a low byte K0. For each byte, an unsigned comparison of the incoming byte against K2 selects between two XOR combinations. The current byte only decides which combination is used. From the second byte on, the data that is mixed comes from history: the previous input byte, the last output or the output before it, plus key bytes.

A small position state machine tracks where the current byte sits in its stream. It has three states. FIRST is the state after reset or after a restart. SECOND means one byte has been taken. STEADY means two or more bytes have been taken.

The machine has the following transitions:
- An accepted byte moves FIRST to SECOND and SECOND to STEADY.
- STEADY stays in STEADY on every accepted byte, so the state saturates.
- A restart pulse without a byte returns the machine to FIRST.
- A restart pulse together with a byte treats that byte as FIRST and lands in SECOND.
- Reset returns the machine to FIRST from any state.

Top module: `keyed_byte_scrambler`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, `dout` is 0x00, and the next accepted byte follows the first-byte rule.
- R2: For the first byte of a stream, `dout` = `din` XOR K2 when `din` >= K2, and `din` XOR K1 otherwise. K2 = `key_i[23:16]`, K1 = `key_i[15:8]`, K0 = `key_i[7:0]`.
- R3: For the second byte, let t = previous input XOR K1. Then `dout` = t XOR first output when `din` >= K2, and t XOR K0 otherwise.
- R4: From the third byte on, `dout` = t XOR previous output when `din` >= K2. Otherwise `dout` = t XOR the output two accepted bytes earlier.
- R5: A byte accepted on a rising edge (`in_valid` = 1) produces its output on `dout` with `out_valid` = 1 right after that same edge. The latency is one register stage.
- R6: A cycle with `in_valid` = 0 gives `out_valid` = 0, leaves `dout` unchanged and changes no history. The next accepted byte is scrambled as if the idle cycle had not happened.
- R7: A `start_i` pulse clears all history and the position. If it comes with `in_valid` = 1, that byte is scrambled as the first byte of a new stream.
- R8: The position saturates in STEADY. A stream of any length keeps using the R4 rule and never falls back to the start-up rules.
- R9: The comparison is unsigned and inclusive: `din` equal to K2 takes the ">=" branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| key_i | input | 24 | Scrambling key, held constant during a stream |
| in_valid | input | 1 | Accept `din` on this edge |
| start_i | input | 1 | Restart pulse: clears history and position |
| din | input | 8 | Input byte |
| out_valid | output | 1 | `dout` carries a fresh scrambled byte |
| dout | output | 8 | Scrambled output byte (registered) |

## Verification
Every scrambled byte is due exactly one rising edge after it is accepted. An idle or restart cycle shows its effect at the same edge: `out_valid` drops and `dout` holds. The bench drives each input at a falling edge and reads `dout` and `out_valid` at the following falling edge, which is the first stable point after the edge that registers the result. The reference model works from a queue of past outputs and a byte counter, not from a state machine. Any lost or spurious history update therefore shows up in the bytes that follow.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        POS_FIRST  = 2'd0,
        POS_SECOND = 2'd1,
        POS_STEADY = 2'd2
    } pos_e;

endpackage

// File: rtl/scr_pos_fsm.sv
module scr_pos_fsm
    import scr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic accept,
    output pos_e pos_q
);

    pos_e pos_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_FIRST;
        end else begin
            pos_q <= pos_d;
        end
    end

    // next position
    always_comb begin
        pos_d = pos_q;
        if (restart) begin
            pos_d = accept ? POS_SECOND : POS_FIRST;
        end else if (accept) begin
            unique case (pos_q)
                POS_FIRST:  pos_d = POS_SECOND;
                POS_SECOND: pos_d = POS_STEADY;
                POS_STEADY: pos_d = POS_STEADY;
                default:    pos_d = POS_FIRST;
            endcase
        end
    end

endmodule

// File: rtl/scr_history.sv
module scr_history #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              accept,
    input  logic [BYTE_W-1:0] din,
    input  logic [BYTE_W-1:0] mixed,
    output logic [BYTE_W-1:0] prev_in_q,
    output logic [BYTE_W-1:0] prev_out_q,
    output logic [BYTE_W-1:0] prev2_out_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_in_q   <= '0;
            prev_out_q  <= '0;
            prev2_out_q <= '0;
        end else if (accept) begin
            prev_in_q   <= din;
            prev_out_q  <= mixed;
            prev2_out_q <= restart ? '0 : prev_out_q;
        end else if (restart) begin
            prev_in_q   <= '0;
            prev_out_q  <= '0;
            prev2_out_q <= '0;
        end
    end

endmodule

// File: rtl/scr_mixer.sv
module scr_mixer
    import scr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  pos_e              pos,
    input  logic [BYTE_W-1:0] din,
    input  logic [BYTE_W-1:0] k_hi,
    input  logic [BYTE_W-1:0] k_mid,
    input  logic [BYTE_W-1:0] k_lo,
    input  logic [BYTE_W-1:0] prev_in,
    input  logic [BYTE_W-1:0] prev_out,
    input  logic [BYTE_W-1:0] prev2_out,
    output logic [BYTE_W-1:0] mixed
);

    logic              take_hi;
    logic [BYTE_W-1:0] carried;

    always_comb begin
        take_hi = (din >= k_hi);
        carried = prev_in ^ k_mid;
        unique case (pos)
            POS_FIRST:  mixed = din ^ (take_hi ? k_hi : k_mid);
            POS_SECOND: mixed = carried ^ (take_hi ? prev_out : k_lo);
            POS_STEADY: mixed = carried ^ (take_hi ? prev_out : prev2_out);
            default:    mixed = '0;
        endcase
    end

endmodule

// File: rtl/keyed_byte_scrambler.sv
module keyed_byte_scrambler
    import scr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3*BYTE_W-1:0] key_i,
    input  logic                in_valid,
    input  logic                start_i,
    input  logic [BYTE_W-1:0]   din,
    output logic                out_valid,
    output logic [BYTE_W-1:0]   dout
);

    localparam int KEY_BYTES = 3;

    logic [BYTE_W-1:0] key_b [KEY_BYTES];

    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key
        assign key_b[g] = key_i[g*BYTE_W +: BYTE_W];
    end

    pos_e              pos_q;
    pos_e              pos_eff;
    logic [BYTE_W-1:0] prev_in_q;
    logic [BYTE_W-1:0] prev_out_q;
    logic [BYTE_W-1:0] prev2_out_q;
    logic [BYTE_W-1:0] mixed;

    // a restart makes the byte of the same cycle the first of a stream
    assign pos_eff = start_i ? POS_FIRST : pos_q;

    scr_pos_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .restart (start_i),
        .accept  (in_valid),
        .pos_q   (pos_q)
    );

    scr_history #(.BYTE_W(BYTE_W)) i_hist (
        .clk         (clk),
        .rst         (rst),
        .restart     (start_i),
        .accept      (in_valid),
        .din         (din),
        .mixed       (mixed),
        .prev_in_q   (prev_in_q),
        .prev_out_q  (prev_out_q),
        .prev2_out_q (prev2_out_q)
    );

    scr_mixer #(.BYTE_W(BYTE_W)) i_mix (
        .pos       (pos_eff),
        .din       (din),
        .k_hi      (key_b[2]),
        .k_mid     (key_b[1]),
        .k_lo      (key_b[0]),
        .prev_in   (prev_in_q),
        .prev_out  (prev_out_q),
        .prev2_out (prev2_out_q),
        .mixed     (mixed)
    );

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dout      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dout <= mixed;
            end
        end
    end

endmodule

// File: rtl/scr_checker.sv
module scr_checker
    import scr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [3*BYTE_W-1:0] key_i,
    input logic                in_valid,
    input logic                start_i,
    input logic [BYTE_W-1:0]   din,
    input logic                out_valid,
    input logic [BYTE_W-1:0]   dout,
    input pos_e                pos_q,
    input logic [BYTE_W-1:0]   prev_in,
    input logic [BYTE_W-1:0]   prev_out,
    input logic [BYTE_W-1:0]   prev2_out
);

    logic [BYTE_W-1:0] k2, k1, k0;
    assign k2 = key_i[3*BYTE_W-1:2*BYTE_W];
    assign k1 = key_i[2*BYTE_W-1:BYTE_W];
    assign k0 = key_i[BYTE_W-1:0];

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(dout)));

    a_r2_first_hi: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (start_i || pos_q == POS_FIRST) && din >= k2)
        |=> dout == $past(din ^ k2));

    a_r3_second_lo: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !start_i && pos_q == POS_SECOND && din < k2)
        |=> dout == $past(prev_in ^ k1 ^ k0));

    a_r4_steady_hi: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !start_i && pos_q == POS_STEADY && din >= k2)
        |=> dout == $past(prev_in ^ k1 ^ prev_out));

    a_r4_steady_lo: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !start_i && pos_q == POS_STEADY && din < k2)
        |=> dout == $past(prev_in ^ k1 ^ prev2_out));

    a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
        (start_i && !in_valid)
        |=> (pos_q == POS_FIRST && prev_in == '0 && prev_out == '0 && prev2_out == '0));

    a_r8_saturates: assert property (@(posedge clk) disable iff (rst)
        (!start_i && pos_q == POS_STEADY) |=> pos_q == POS_STEADY);

endmodule

bind keyed_byte_scrambler scr_checker #(.BYTE_W(BYTE_W)) i_scr_checker (
    .clk       (clk),
    .rst       (rst),
    .key_i     (key_i),
    .in_valid  (in_valid),
    .start_i   (start_i),
    .din       (din),
    .out_valid (out_valid),
    .dout      (dout),
    .pos_q     (pos_q),
    .prev_in   (prev_in_q),
    .prev_out  (prev_out_q),
    .prev2_out (prev2_out_q)
);

// File: tb/test_keyed_byte_scrambler.sv
module test_keyed_byte_scrambler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [23:0] key = 24'h80_3C_A5;
    logic        out_valid;
    logic [7:0]  dout;

    always #4 clk = ~clk;

    keyed_byte_scrambler i_keyed_byte_scrambler (
        .clk       (clk),
        .rst       (rst),
        .key_i     (key),
        .in_valid  (in_valid),
        .start_i   (start_i),
        .din       (din),
        .out_valid (out_valid),
        .dout      (dout)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    int         m_count = 0;
    logic [7:0] m_prev_in = 8'h00;
    logic [7:0] m_outs[$];
    logic [7:0] exp_dout = 8'h00;
    bit         exp_valid = 1'b0;

    task automatic check(input string tag);
        checks++;
        if (out_valid !== exp_valid || dout !== exp_dout) begin
            errors++;
            $display("FAIL %s: out_valid=%0b dout=%02h expected out_valid=%0b dout=%02h",
                     tag, out_valid, dout, exp_valid, exp_dout);
        end
    endtask

    task automatic model_accept(input logic [7:0] d);
        logic [7:0] k2, k1, k0, t, o;
        bit ge;
        k2 = key[23:16];
        k1 = key[15:8];
        k0 = key[7:0];
        ge = (int'(d) >= int'(k2));
        t  = m_prev_in ^ k1;
        if (m_count == 0)      o = ge ? (d ^ k2) : (d ^ k1);
        else if (m_count == 1) o = ge ? (t ^ m_outs[m_outs.size()-1]) : (t ^ k0);
        else                   o = ge ? (t ^ m_outs[m_outs.size()-1]) : (t ^ m_outs[m_outs.size()-2]);
        m_outs.push_back(o);
        if (m_outs.size() > 2) void'(m_outs.pop_front());
        m_prev_in = d;
        m_count++;
        exp_dout  = o;
        exp_valid = 1'b1;
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic step(input bit v, input bit s, input logic [7:0] d);
        string tag;
        if (!v)                    tag = s ? "R7" : "R6";
        else if (s)                tag = "R7/R5";
        else if (d == key[23:16])  tag = "R9/R5";
        else if (m_count == 0)     tag = "R2/R5";
        else if (m_count == 1)     tag = "R3/R5";
        else if (m_count > 200)    tag = "R8/R4";
        else                       tag = "R4/R5";
        in_valid = v;
        start_i  = s;
        din      = d;
        if (s) begin
            m_count   = 0;
            m_prev_in = 8'h00;
            m_outs.delete();
        end
        if (v) model_accept(d);
        else   exp_valid = 1'b0;
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        start_i  = 1'b0;
        @(negedge clk);
        rst       = 1'b0;
        m_count   = 0;
        m_prev_in = 8'h00;
        m_outs.delete();
        exp_dout  = 8'h00;
        exp_valid = 1'b0;
        check("R1");
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: first byte after reset uses first-byte rule (below K2)
        step(1, 0, 8'h12);
        do_reset();
        step(1, 0, 8'h91);   // R2 hi
        step(1, 0, 8'h12);   // R3 lo
        step(1, 0, 8'hC4);   // R4 hi
        step(1, 0, 8'h05);   // R4 lo
        step(0, 0, 8'hFF);   // R6 idle
        step(0, 0, 8'h00);   // R6 idle
        step(1, 0, 8'h80);   // R9 equal
        step(1, 0, 8'h7F);   // R9 just below
        // R7: restart without a byte
        step(0, 1, 8'h00);
        step(1, 0, 8'h10);
        step(1, 0, 8'hF0);   // R3 hi
        step(1, 0, 8'h33);
        // R7: restart with a byte, and R9 on the first byte
        step(1, 1, 8'h80);
        step(1, 0, 8'h01);
        step(1, 0, 8'h80);
        // R1: mid-stream reset
        step(1, 0, 8'h44);
        do_reset();
        step(1, 0, 8'h7F);
        step(1, 0, 8'hEE);
        // R8: long stream with gaps
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 5) != 0, 1'b0, 8'($urandom));
        end
        // other keys: K2 = 0 (always hi), K2 = FF (only FF is hi)
        key = 24'h00_FF_0F;
        do_reset();
        for (int i = 0; i < 20; i++) step(1, 0, 8'($urandom));
        key = 24'hFF_5A_C3;
        do_reset();
        for (int i = 0; i < 20; i++) step(1, 0, (i % 4 == 0) ? 8'hFF : 8'($urandom));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule